// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the bus write port of a parallel NOR-style flash controller. Each clock cycle in which `wr_valid` is high it takes one latched bus write (an 18-bit address and an 8-bit data byte). It follows the two-write unlock prefix and the command bytes that come after it. When a command completes, it raises one single-cycle request: a byte program, or an erase with a mask of the regions to clear. It also holds two flags, boot-region lockout and product-identification mode, which the read path and the array sequencer use.

The address space has five regions:
- a 16 KiB boot region;
- two 8 KiB parameter regions;
- a 96 KiB main region 1;
- a 128 KiB main region 2.

By default the boot region sits at the bottom of the space. A parameter mirrors the whole map to the top end. While the lockout flag is set and the override input is low, program and erase requests that aim at the boot region are suppressed. The array timing is handled elsewhere and reported back on `erase_busy`. While that input is high, every bus write is discarded.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `prog_req` and `erase_req` are 0, `erase_mask` is 0, and `lock_flag` and `id_mode` are 0.
- R2: Unlock and command writes compare only address bits [14:0]. The first unlock write is AA to x5555 and the second is 55 to x2AAA, so AA to 18'h15555 also counts as a first unlock write.
- R3: Unlock, then A0 to x5555, then a write of (A, D) gives `prog_req`=1 with `prog_addr`=A and `prog_data`=D in the cycle after the write of D.
- R4: Unlock, 80 to x5555, unlock, then 10 to x5555 gives a chip erase. The mask is 5'b11111, or 5'b11110 when the boot region is locked. Mask bit order is [0] boot, [1] param1, [2] param2, [3] main1, [4] main2.
- R5: Unlock, 80, unlock, then 30 to address S gives a sector erase of the region holding S. The masks are:
  - boot (00000–03FFF): 5'b00001
  - param1 (04000–05FFF): 5'b00010
  - param2 (06000–07FFF): 5'b00100
  - main1 (08000–1FFFF): 5'b01110, which also clears both parameter regions
  - main2 (20000–3FFFF): 5'b10000
- R6: Unlock, 80, unlock, then 40 to x5555 sets `lock_flag`. It stays set until reset, and the command raises no request.
- R7: While `lock_flag`=1 and `lock_override`=0, a program or sector erase that targets the boot region raises no request and the decoder returns to idle. With `lock_override`=1 the request is issued.
- R8: Unlock plus 90 to x5555 sets `id_mode`. Either unlock plus F0 to x5555, or a single F0 write to any address from idle, clears it.
- R9: While `erase_busy`=1, writes neither raise requests nor advance the sequence.
- R10: A write that does not match the expected step returns the decoder to idle with no request.
- R11: Each request lasts exactly one cycle. `prog_req` and `erase_req` are never high together, and `erase_req` is never high with an all-zero mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A latched bus write is present this cycle |
| wr_addr | input | 18 | Write address |
| wr_data | input | 8 | Write data |
| erase_busy | input | 1 | An erase is running; writes are discarded |
| lock_override | input | 1 | Bypasses the boot-region lockout |
| prog_req | output | 1 | Single-cycle byte program request |
| prog_addr | output | 18 | Program target address |
| prog_data | output | 8 | Program data byte |
| erase_req | output | 1 | Single-cycle erase request |
| erase_mask | output | 5 | Regions to erase, bit order per R4 |
| lock_flag | output | 1 | Boot-region lockout is active |
| id_mode | output | 1 | Product-identification mode is active |

## Verification
Random program and sector-erase sequences draw their target addresses across the whole space, with random override settings, both before and after lockout. This separates the region decode, including the main1 widening, from the boot guard. Directed sequences cover the following:
- unlock writes with high address bits set, which shows that only the low address bits are compared;
- broken sequences, which show the return to idle;
- busy-time writes, which must neither issue requests nor leave the decoder part-way through a sequence;
- both ID-exit forms.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
   localparam int REGION_N = 5;
   localparam int RG_BOOT  = 0;
   localparam int RG_PAR1  = 1;
   localparam int RG_PAR2  = 2;
   localparam int RG_MAIN1 = 3;
   localparam int RG_MAIN2 = 4;

   localparam logic [7:0] BYTE_UNL1  = 8'hAA;
   localparam logic [7:0] BYTE_UNL2  = 8'h55;
   localparam logic [7:0] BYTE_PROG  = 8'hA0;
   localparam logic [7:0] BYTE_ERASE = 8'h80;
   localparam logic [7:0] BYTE_IDIN  = 8'h90;
   localparam logic [7:0] BYTE_IDOUT = 8'hF0;
   localparam logic [7:0] BYTE_CHIP  = 8'h10;
   localparam logic [7:0] BYTE_SECT  = 8'h30;
   localparam logic [7:0] BYTE_LOCK  = 8'h40;

   typedef enum logic [2:0] {
      ST_IDLE, ST_UL1, ST_UL2, ST_PGM, ST_EX1, ST_EX2, ST_EX3
   } seq_state_t;

   typedef enum logic [2:0] {
      CMD_NONE, CMD_PROG, CMD_CHIP, CMD_SECT, CMD_LOCK, CMD_ID_IN, CMD_ID_OUT
   } cmd_t;
endpackage

// File: rtl/fcd_region_map.sv
module fcd_region_map
   import flash_cmd_pkg::*;
#(
   parameter int          ADDR_W      = 18,
   parameter bit          BOOT_AT_TOP = 1'b0,
   parameter logic [17:0] P1_BASE     = 18'h04000,
   parameter logic [17:0] P2_BASE     = 18'h06000,
   parameter logic [17:0] M1_BASE     = 18'h08000,
   parameter logic [17:0] M2_BASE     = 18'h20000
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic [REGION_N-1:0] hit
);
   logic [ADDR_W-1:0] norm;

   generate
      if (BOOT_AT_TOP) begin : g_top
         assign norm = ~addr;
      end else begin : g_bottom
         assign norm = addr;
      end
   endgenerate

   always_comb begin
      hit = '0;
      if (norm < ADDR_W'(P1_BASE))      hit[RG_BOOT]  = 1'b1;
      else if (norm < ADDR_W'(P2_BASE)) hit[RG_PAR1]  = 1'b1;
      else if (norm < ADDR_W'(M1_BASE)) hit[RG_PAR2]  = 1'b1;
      else if (norm < ADDR_W'(M2_BASE)) hit[RG_MAIN1] = 1'b1;
      else                              hit[RG_MAIN2] = 1'b1;
   end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W  = 18,
   parameter int DATA_W  = 8,
   parameter int MATCH_W = 15,
   parameter logic [MATCH_W-1:0] UNL_ADDR1 = 15'h5555,
   parameter logic [MATCH_W-1:0] UNL_ADDR2 = 15'h2AAA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              hold,
   output cmd_t              cmd
);
   seq_state_t st_q, st_d;
   logic at1, at2, take;

   assign at1  = (wr_addr[MATCH_W-1:0] == UNL_ADDR1);
   assign at2  = (wr_addr[MATCH_W-1:0] == UNL_ADDR2);
   assign take = wr_valid && !hold;

   always_comb begin
      st_d = st_q;
      cmd  = CMD_NONE;
      if (take) begin
         st_d = ST_IDLE;
         unique case (st_q)
            ST_IDLE: begin
               if (at1 && wr_data == BYTE_UNL1) st_d = ST_UL1;
               else if (wr_data == BYTE_IDOUT)  cmd  = CMD_ID_OUT;
            end
            ST_UL1: if (at2 && wr_data == BYTE_UNL2) st_d = ST_UL2;
            ST_UL2: begin
               if (at1) begin
                  case (wr_data)
                     BYTE_PROG:  st_d = ST_PGM;
                     BYTE_ERASE: st_d = ST_EX1;
                     BYTE_IDIN:  cmd  = CMD_ID_IN;
                     BYTE_IDOUT: cmd  = CMD_ID_OUT;
                     default:    st_d = ST_IDLE;
                  endcase
               end
            end
            ST_PGM: cmd = CMD_PROG;
            ST_EX1: if (at1 && wr_data == BYTE_UNL1) st_d = ST_EX2;
            ST_EX2: if (at2 && wr_data == BYTE_UNL2) st_d = ST_EX3;
            ST_EX3: begin
               if (wr_data == BYTE_SECT)              cmd = CMD_SECT;
               else if (at1 && wr_data == BYTE_CHIP)  cmd = CMD_CHIP;
               else if (at1 && wr_data == BYTE_LOCK)  cmd = CMD_LOCK;
            end
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end
endmodule

// File: rtl/fcd_req_gen.sv
module fcd_req_gen
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  cmd_t                cmd,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   data,
   input  logic [REGION_N-1:0] hit,
   input  logic                lock_override,
   output logic                prog_req,
   output logic [ADDR_W-1:0]   prog_addr,
   output logic [DATA_W-1:0]   prog_data,
   output logic                erase_req,
   output logic [REGION_N-1:0] erase_mask,
   output logic                lock_flag,
   output logic                id_mode
);
   logic                eff_lock, boot_blk, prog_d;
   logic [REGION_N-1:0] mask_d, all_mask;

   assign eff_lock = lock_flag && !lock_override;
   assign boot_blk = hit[RG_BOOT] && eff_lock;
   assign all_mask = {REGION_N{1'b1}};

   always_comb begin
      prog_d = (cmd == CMD_PROG) && !boot_blk;
      mask_d = '0;
      if (cmd == CMD_CHIP) begin
         mask_d = all_mask;
         if (eff_lock) mask_d[RG_BOOT] = 1'b0;
      end else if (cmd == CMD_SECT && !boot_blk) begin
         mask_d = hit;
         if (hit[RG_MAIN1]) begin
            mask_d[RG_PAR1] = 1'b1;
            mask_d[RG_PAR2] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prog_req   <= 1'b0;
         prog_addr  <= '0;
         prog_data  <= '0;
         erase_req  <= 1'b0;
         erase_mask <= '0;
         lock_flag  <= 1'b0;
         id_mode    <= 1'b0;
      end else begin
         prog_req   <= prog_d;
         erase_req  <= |mask_d;
         erase_mask <= mask_d;
         if (prog_d) begin
            prog_addr <= addr;
            prog_data <= data;
         end
         if (cmd == CMD_LOCK)   lock_flag <= 1'b1;
         if (cmd == CMD_ID_IN)  id_mode   <= 1'b1;
         if (cmd == CMD_ID_OUT) id_mode   <= 1'b0;
      end
   end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import flash_cmd_pkg::*;
#(
   parameter int          ADDR_W      = 18,
   parameter int          DATA_W      = 8,
   parameter int          MATCH_W     = 15,
   parameter bit          BOOT_AT_TOP = 1'b0,
   parameter logic [17:0] P1_BASE     = 18'h04000,
   parameter logic [17:0] P2_BASE     = 18'h06000,
   parameter logic [17:0] M1_BASE     = 18'h08000,
   parameter logic [17:0] M2_BASE     = 18'h20000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              erase_busy,
   input  logic              lock_override,
   output logic              prog_req,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [DATA_W-1:0] prog_data,
   output logic              erase_req,
   output logic [4:0]        erase_mask,
   output logic              lock_flag,
   output logic              id_mode
);
   localparam logic [MATCH_W-1:0] UNL_ADDR1 = MATCH_W'(15'h5555);
   localparam logic [MATCH_W-1:0] UNL_ADDR2 = MATCH_W'(15'h2AAA);

   generate
      if (ADDR_W < MATCH_W || ADDR_W > 18)
         $error("flash_cmd_decoder: ADDR_W must lie between MATCH_W and 18");
      if (DATA_W != 8)
         $error("flash_cmd_decoder: command bytes need DATA_W of 8");
      if (!(P1_BASE < P2_BASE && P2_BASE < M1_BASE && M1_BASE < M2_BASE))
         $error("flash_cmd_decoder: region bases must ascend");
   endgenerate

   cmd_t                cmd;
   logic [REGION_N-1:0] hit;

   fcd_seq_fsm #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MATCH_W(MATCH_W),
      .UNL_ADDR1(UNL_ADDR1), .UNL_ADDR2(UNL_ADDR2)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .hold(erase_busy), .cmd(cmd)
   );

   fcd_region_map #(
      .ADDR_W(ADDR_W), .BOOT_AT_TOP(BOOT_AT_TOP), .P1_BASE(P1_BASE),
      .P2_BASE(P2_BASE), .M1_BASE(M1_BASE), .M2_BASE(M2_BASE)
   ) u_map (
      .addr(wr_addr), .hit(hit)
   );

   fcd_req_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(wr_addr), .data(wr_data),
      .hit(hit), .lock_override(lock_override), .prog_req(prog_req),
      .prog_addr(prog_addr), .prog_data(prog_data), .erase_req(erase_req),
      .erase_mask(erase_mask), .lock_flag(lock_flag), .id_mode(id_mode)
   );
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_valid,
   input logic       erase_busy,
   input logic       lock_override,
   input logic       prog_req,
   input logic       erase_req,
   input logic [4:0] erase_mask,
   input logic       lock_flag
);
   p_req_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(prog_req && erase_req));

   p_mask_nonzero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> (erase_mask != 5'b0));

   p_req_needs_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_req || erase_req) |-> $past(wr_valid));

   p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(erase_busy) |-> (!prog_req && !erase_req));

   p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lock_flag |=> lock_flag);

   p_boot_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_req && $past(lock_flag && !lock_override)) |-> !erase_mask[0]);

   p_main1_widen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_req && erase_mask[3]) |-> (erase_mask[2:1] == 2'b11));
endmodule

bind flash_cmd_decoder fcd_checker u_chk (
   .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .erase_busy(erase_busy),
   .lock_override(lock_override), .prog_req(prog_req), .erase_req(erase_req),
   .erase_mask(erase_mask), .lock_flag(lock_flag)
);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic [17:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        erase_busy = 1'b0;
   logic        lock_override = 1'b0;
   logic        prog_req, erase_req, lock_flag, id_mode;
   logic [17:0] prog_addr;
   logic [7:0]  prog_data;
   logic [4:0]  erase_mask;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic        s_prog, s_erase;
   logic [17:0] s_paddr;
   logic [7:0]  s_pdata;
   logic [4:0]  s_mask;
   bit          m_lock = 1'b0;

   always #5 clk = ~clk;

   flash_cmd_decoder u_flash_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .erase_busy(erase_busy), .lock_override(lock_override),
      .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
      .erase_req(erase_req), .erase_mask(erase_mask), .lock_flag(lock_flag),
      .id_mode(id_mode)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [17:0] a, logic [7:0] d);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
      s_prog = prog_req; s_erase = erase_req; s_mask = erase_mask;
      s_paddr = prog_addr; s_pdata = prog_data;
   endtask

   task automatic unlock();
      wr(18'h05555, 8'hAA);
      wr(18'h02AAA, 8'h55);
   endtask

   task automatic do_prog(logic [17:0] a, logic [7:0] d);
      unlock(); wr(18'h05555, 8'hA0); wr(a, d);
   endtask

   task automatic do_erase(logic [17:0] a, logic [7:0] d);
      unlock(); wr(18'h05555, 8'h80); unlock(); wr(a, d);
   endtask

   function automatic logic [4:0] exp_sector(logic [17:0] a, bit lk);
      if (a < 18'h04000)      return lk ? 5'b00000 : 5'b00001;
      else if (a < 18'h06000) return 5'b00010;
      else if (a < 18'h08000) return 5'b00100;
      else if (a < 18'h20000) return 5'b01110;
      else                    return 5'b10000;
   endfunction

   function automatic bit exp_prog(logic [17:0] a, bit lk);
      return !(a < 18'h04000 && lk);
   endfunction

   task automatic random_round(int n);
      for (int i = 0; i < n; i++) begin
         logic [17:0] a;
         logic [7:0]  d;
         bit          ov, lk;
         a  = 18'($urandom);
         d  = 8'($urandom);
         ov = 1'($urandom);
         if (($urandom % 4) == 0) a = 18'($urandom % 32'h4000);
         lock_override = ov;
         lk = m_lock && !ov;
         if ($urandom % 2) begin
            do_prog(a, d);
            check("R3/R7 random prog_req", 32'(s_prog), 32'(exp_prog(a, lk)));
            if (exp_prog(a, lk))
               check("R3 random prog addr/data", {6'd0, s_paddr, s_pdata}, {6'd0, a, d});
         end else begin
            do_erase(a, 8'h30);
            check("R5/R7 random sector mask", 32'(s_mask), 32'(exp_sector(a, lk)));
            check("R11 random erase_req", 32'(s_erase), 32'(exp_sector(a, lk) != 0));
         end
         lock_override = 1'b0;
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1 reset requests", {30'd0, prog_req, erase_req}, 32'd0);
      check("R1 reset flags", {27'd0, erase_mask}, 32'd0);
      check("R1 reset lock/id", {30'd0, lock_flag, id_mode}, 32'd0);
      rst_n = 1'b1;

      do_prog(18'h12345, 8'h5A);
      check("R3 prog_req", 32'(s_prog), 32'd1);
      check("R3 prog addr/data", {6'd0, s_paddr, s_pdata}, {6'd0, 18'h12345, 8'h5A});
      @(negedge clk);
      check("R11 prog pulse one cycle", 32'(prog_req), 32'd0);

      wr(18'h15555, 8'hAA); wr(18'h32AAA, 8'h55); wr(18'h25555, 8'hA0);
      wr(18'h2F00F, 8'h3C);
      check("R2 upper bits ignored", {7'd0, s_prog, s_paddr}, {7'd0, 1'b1, 18'h2F00F});

      do_erase(18'h05555, 8'h10);
      check("R4 chip erase unlocked", {26'd0, s_erase, s_mask}, {26'd0, 1'b1, 5'b11111});
      @(negedge clk);
      check("R11 erase pulse one cycle", 32'(erase_req), 32'd0);

      do_erase(18'h00010, 8'h30); check("R5 boot sector", 32'(s_mask), 32'h01);
      do_erase(18'h05FFF, 8'h30); check("R5 param1", 32'(s_mask), 32'h02);
      do_erase(18'h06000, 8'h30); check("R5 param2", 32'(s_mask), 32'h04);
      do_erase(18'h1FFFF, 8'h30); check("R5 main1 widens", 32'(s_mask), 32'h0E);
      do_erase(18'h20000, 8'h30); check("R5 main2", 32'(s_mask), 32'h10);

      wr(18'h05555, 8'hAA); wr(18'h02AAB, 8'h55); wr(18'h05555, 8'hA0);
      wr(18'h01234, 8'h77);
      check("R10 broken unlock no request", {30'd0, s_prog, s_erase}, 32'd0);
      unlock(); wr(18'h05555, 8'h80); wr(18'h05555, 8'hAB); wr(18'h02AAA, 8'h55);
      wr(18'h05555, 8'h10);
      check("R10 broken erase no request", {30'd0, s_prog, s_erase}, 32'd0);

      unlock(); wr(18'h05555, 8'h90);
      check("R8 id entry", 32'(id_mode), 32'd1);
      wr(18'h3ABCD, 8'hF0);
      check("R8 single F0 exit", 32'(id_mode), 32'd0);
      unlock(); wr(18'h05555, 8'h90);
      unlock(); wr(18'h05555, 8'hF0);
      check("R8 unlock F0 exit", 32'(id_mode), 32'd0);

      erase_busy = 1'b1;
      do_prog(18'h10000, 8'h11);
      check("R9 busy program dropped", {30'd0, s_prog, s_erase}, 32'd0);
      unlock();
      erase_busy = 1'b0;
      wr(18'h05555, 8'hA0); wr(18'h10000, 8'h22);
      check("R9 busy writes do not advance", 32'(s_prog), 32'd0);

      random_round(60);

      do_erase(18'h05555, 8'h40);
      m_lock = 1'b1;
      check("R6 lockout set", {30'd0, lock_flag, s_erase | s_prog}, 32'd2);
      do_erase(18'h05555, 8'h10);
      check("R4 chip erase locked", {26'd0, s_erase, s_mask}, {26'd0, 1'b1, 5'b11110});
      check("R6 lockout sticky", 32'(lock_flag), 32'd1);
      do_erase(18'h03FFF, 8'h30);
      check("R7 boot erase blocked", {26'd0, s_erase, s_mask}, 32'd0);
      do_prog(18'h00100, 8'h00);
      check("R7 boot program blocked", 32'(s_prog), 32'd0);
      lock_override = 1'b1;
      do_erase(18'h00000, 8'h30);
      check("R7 override boot erase", 32'(s_mask), 32'h01);
      do_prog(18'h00100, 8'h00);
      check("R7 override boot program", 32'(s_prog), 32'd1);
      lock_override = 1'b0;

      random_round(60);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule